// File: doc/BRIEF.md
# Protected-Frame Fragment Rejoiner and IV Stripper

This block sits on the receive side of a layer-2 link protection path. Protected frames arrive on a 32-bit streaming bus. Each one carries a 4-byte signaling word straight after the 2-byte Ethernet type field, followed by a 16-byte initialization vector (IV) and then the payload. The block reads the signaling word and does one of three things with the frame. An unsplit frame goes straight to field removal. The first part of a split frame is held. The second part is appended to the held first part when both carry the same packet index.

Each completed frame leaves the block as the original 14-byte header followed directly by the payload, with the signaling word and the IV removed. The frame is therefore 20 bytes shorter than the protected form. The IV of the frame is presented on a separate port, together with the first output word, for the keystream path. Fragments that are lost, arrive out of order, or have inconsistent lengths are discarded by fixed rules. Decryption and CRC handling sit outside this block.

The block works store-and-forward. A frame is written into an internal byte store while it arrives. The block then plays the frame out at one word per cycle. It deasserts its ready output while it does so.

Top module: `frag_rejoin_strip`

## Requirements
- R1: After reset, outValid and ivValid are low and inReady is high.
- R2: Byte numbering and field decoding.
  - Bytes travel big-endian within each word: byte 0 of a word is in bits [31:24]. inEmpty gives the number of unused trailing bytes in the word that carries inEop. inSop restarts byte numbering at 0.
  - The signaling word is frame bytes 14..17, read big-endian. In that word, bit 0 = split, bit 1 = second part, bits 8..18 = payload size and bits 19..29 = packet index.
  - A valid frame with the split bit at 0 is output as bytes 0..13 followed by bytes 34..end.
- R3: Output framing. Output bytes use the same byte order as the input. outSop is high on the first output word only and outEop on the last word only. outEmpty equals (4 - length mod 4) mod 4 on the last word and 0 on every other word.
- R4: IV port. ivData carries input bytes 18..33, with byte 18 in bits [127:120]. ivValid is high only in the outSop cycle. ivData stays stable while the frame is output. For a rejoined frame, ivData carries the first part's IV.
- R5: Holding the first part. A valid frame with split = 1 and second = 0 produces no output and is held.
- R6: Rejoining. A valid frame with split = 1 and second = 1 is joined to the held part when its packet index equals the held one. The output is the first part's header, then the first part's payload, then the second part's payload. The second part's header is ignored.
- R7: Orphan or mismatched second part. A second part that arrives with no held part, or with a different packet index, produces no output and releases any held part.
- R8: Any other frame completed while a part is held releases the held part. A later matching second part then produces no output.
- R9: Length checks. A frame is discarded in either of these cases:
  - it is shorter than 34 bytes;
  - its size field differs from the number of payload bytes received (total bytes minus 34).
  
  A second part that fails these checks also discards its held first part.
- R10: Capacity. A frame whose payload, or joined payload, exceeds DATA_BYTES (default 2048) is discarded. A payload of exactly DATA_BYTES is output.
- R11: Output timing.
  - Output starts in the cycle after the accepting edge of the inEop word of a completing frame.
  - Output words follow each other in consecutive cycles.
  - inReady is low while output is in progress.
  - At least one idle cycle follows outEop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 32 | Input word, byte 0 in bits [31:24] |
| inValid | input | 1 | Input word present |
| inSop | input | 1 | First word of an input frame |
| inEop | input | 1 | Last word of an input frame |
| inEmpty | input | 2 | Unused trailing bytes in the last input word |
| inReady | output | 1 | Block accepts an input word in this cycle |
| outData | output | 32 | Output word of the restored frame |
| outValid | output | 1 | Output word present |
| outSop | output | 1 | First word of an output frame |
| outEop | output | 1 | Last word of an output frame |
| outEmpty | output | 2 | Unused trailing bytes in the last output word |
| ivData | output | 128 | IV of the frame being output |
| ivValid | output | 1 | IV strobe, aligned with outSop |

## Verification
The assertions check the shape of the output stream on every cycle:
- the input is stalled while output is in progress;
- words follow each other without gaps, with one outSop and an idle cycle after outEop;
- outEmpty is zero except on the last word;
- the IV strobe falls on outSop, and ivData is held stable through the frame.

Only the bench scenarios can show the content decisions. These are the byte-exact removal of the 20 inserted bytes for every payload-length residue, and the concatenation of two fragments at every alignment. They also cover which header and IV survive a join, and the discard rules for mismatched indices, orphans, intervening frames, wrong size fields, short frames and capacity overflow.

// File: rtl/rejoin_pkg.sv
package rejoin_pkg;
  localparam int HDR_BYTES = 14;
  localparam int SIG_BYTES = 4;
  localparam int IV_BYTES  = 16;
  localparam int SIG_OFS   = HDR_BYTES;
  localparam int IV_OFS    = SIG_OFS + SIG_BYTES;
  localparam int DATA_OFS  = IV_OFS + IV_BYTES;
  localparam int LANES     = 4;
  localparam int POS_W     = 16;
  localparam int LEN_W     = 13;
  localparam int WORD_W    = 11;
  localparam int SIZE_W    = 11;
  localparam int IDX_W     = 11;

  // strobes and operands from control to datapath
  typedef struct packed {
    logic              accept;    // input beat taken this cycle
    logic              commit;    // copy header/IV of this frame into hold regs
    logic [LEN_W-1:0]  wrBase;    // byte offset where this frame's payload lands
    logic [LEN_W-1:0]  emitLen;   // payload length of frame being emitted
    logic [WORD_W-1:0] emitWord;  // output word index
  } rejoinCtl_t;

  function automatic logic sigIsSplit(input logic [31:0] s);
    return s[0];
  endfunction
  function automatic logic sigIsSecond(input logic [31:0] s);
    return s[1];
  endfunction
  function automatic logic [SIZE_W-1:0] sigSize(input logic [31:0] s);
    return s[18:8];
  endfunction
  function automatic logic [IDX_W-1:0] sigIndex(input logic [31:0] s);
    return s[29:19];
  endfunction
endpackage

// File: rtl/rejoin_dpath.sv
module rejoin_dpath
  import rejoin_pkg::*;
#(
  parameter int DATA_BYTES = 2048,
  localparam int AW = $clog2(DATA_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rejoinCtl_t        ctl,
  input  logic [31:0]       inData,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [1:0]        inEmpty,
  output logic [31:0]       sigNow,
  output logic [POS_W-1:0]  rxBytes,
  output logic [31:0]       outData,
  output logic [127:0]      ivData
);
  logic [POS_W-1:0] bytePos, posBase;
  logic [2:0]       nValid;

  logic [7:0] hdrCur  [HDR_BYTES];
  logic [7:0] hdrNext [HDR_BYTES];
  logic [7:0] hdrHold [HDR_BYTES];
  logic [7:0] sigCur  [SIG_BYTES];
  logic [7:0] sigNext [SIG_BYTES];
  logic [7:0] ivCur   [IV_BYTES];
  logic [7:0] ivNext  [IV_BYTES];
  logic [7:0] ivHold  [IV_BYTES];
  logic [7:0] dataMem [DATA_BYTES];

  logic [7:0]       inByte  [LANES];
  logic             laneOk  [LANES];
  logic [POS_W-1:0] lanePos [LANES];
  logic [POS_W-1:0] wrAddr  [LANES];
  logic             wrEn    [LANES];

  assign posBase = inSop ? '0 : bytePos;
  assign nValid  = inEop ? (3'd4 - {1'b0, inEmpty}) : 3'd4;
  assign rxBytes = posBase + POS_W'(nValid);

  // per-lane input decode
  generate
    for (genvar g = 0; g < LANES; g++) begin : gLaneIn
      assign inByte[g]  = inData[31-8*g -: 8];
      assign lanePos[g] = posBase + POS_W'(g);
      assign laneOk[g]  = ctl.accept && (3'(g) < nValid);
      assign wrAddr[g]  = POS_W'(ctl.wrBase) + lanePos[g] - POS_W'(DATA_OFS);
      assign wrEn[g]    = laneOk[g] && (lanePos[g] >= POS_W'(DATA_OFS)) &&
                          (wrAddr[g] < POS_W'(DATA_BYTES));
    end
  endgenerate

  // next values of the captured leading fields
  always_comb begin
    hdrNext = hdrCur;
    sigNext = sigCur;
    ivNext  = ivCur;
    for (int i = 0; i < LANES; i++) begin
      if (laneOk[i]) begin
        for (int j = 0; j < HDR_BYTES; j++)
          if (lanePos[i] == POS_W'(j)) hdrNext[j] = inByte[i];
        for (int j = 0; j < SIG_BYTES; j++)
          if (lanePos[i] == POS_W'(SIG_OFS + j)) sigNext[j] = inByte[i];
        for (int j = 0; j < IV_BYTES; j++)
          if (lanePos[i] == POS_W'(IV_OFS + j)) ivNext[j] = inByte[i];
      end
    end
  end

  assign sigNow = {sigNext[0], sigNext[1], sigNext[2], sigNext[3]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bytePos <= '0;
      for (int j = 0; j < HDR_BYTES; j++) begin
        hdrCur[j]  <= '0;
        hdrHold[j] <= '0;
      end
      for (int j = 0; j < SIG_BYTES; j++) sigCur[j] <= '0;
      for (int j = 0; j < IV_BYTES; j++) begin
        ivCur[j]  <= '0;
        ivHold[j] <= '0;
      end
    end else begin
      if (ctl.accept) begin
        bytePos <= inEop ? '0 : posBase + POS_W'(LANES);
        hdrCur  <= hdrNext;
        sigCur  <= sigNext;
        ivCur   <= ivNext;
      end
      if (ctl.commit) begin
        hdrHold <= hdrNext;
        ivHold  <= ivNext;
      end
    end
  end

  // payload store, byte addressed, up to four writes per beat
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wrEn[i]) dataMem[wrAddr[i][AW-1:0]] <= inByte[i];
  end

  // per-lane output assembly: header bytes then payload
  generate
    for (genvar g = 0; g < LANES; g++) begin : gLaneOut
      logic [POS_W-1:0] outPos, dataIdx;
      logic [7:0]       outByte;
      assign outPos  = POS_W'({ctl.emitWord, 2'(g)});
      assign dataIdx = outPos - POS_W'(HDR_BYTES);
      always_comb begin
        if (outPos < POS_W'(HDR_BYTES))
          outByte = hdrHold[outPos[3:0]];
        else if (dataIdx < POS_W'(ctl.emitLen))
          outByte = dataMem[dataIdx[AW-1:0]];
        else
          outByte = '0;
      end
      assign outData[31-8*g -: 8] = outByte;
    end
  endgenerate

  always_comb begin
    for (int j = 0; j < IV_BYTES; j++) ivData[127-8*j -: 8] = ivHold[j];
  end
endmodule

// File: rtl/rejoin_ctrl.sv
module rejoin_ctrl
  import rejoin_pkg::*;
#(
  parameter int DATA_BYTES = 2048
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inEop,
  input  logic [31:0]      sigNow,
  input  logic [POS_W-1:0] rxBytes,
  output logic             inReady,
  output rejoinCtl_t       ctl,
  output logic             outValid,
  output logic             outSop,
  output logic             outEop,
  output logic [1:0]       outEmpty,
  output logic             ivValid
);
  typedef enum logic {ST_RECV, ST_EMIT} state_t;
  state_t state;

  logic              holdValid;
  logic [IDX_W-1:0]  holdIdx;
  logic [LEN_W-1:0]  holdLen, emitLenR, wrBase, newLen;
  logic [WORD_W-1:0] wordCnt, lastWord;
  logic [1:0]        emptyR;

  logic accept, eopFire, isSplit, isSecond, matchHold, lenOk, shortFrame;
  logic goUnsplit, goFirst, goJoin;
  logic [SIZE_W-1:0] sizeF;
  logic [IDX_W-1:0]  idxF;
  logic [POS_W-1:0]  dataCnt, joinEnd, totBytes;
  logic unusedSigBits;

  assign unusedSigBits = ^{sigNow[31:30], sigNow[7:2]};

  assign inReady  = (state == ST_RECV);
  assign accept   = inValid && inReady;
  assign eopFire  = accept && inEop;

  assign isSplit  = sigIsSplit(sigNow);
  assign isSecond = sigIsSecond(sigNow);
  assign sizeF    = sigSize(sigNow);
  assign idxF     = sigIndex(sigNow);

  assign matchHold  = holdValid && isSplit && isSecond && (idxF == holdIdx);
  assign wrBase     = matchHold ? holdLen : '0;
  assign shortFrame = rxBytes < POS_W'(DATA_OFS);
  assign dataCnt    = rxBytes - POS_W'(DATA_OFS);
  assign joinEnd    = POS_W'(wrBase) + dataCnt;
  assign lenOk      = !shortFrame && (dataCnt == POS_W'(sizeF)) &&
                      (joinEnd <= POS_W'(DATA_BYTES));
  assign newLen     = LEN_W'(joinEnd);
  assign totBytes   = POS_W'(newLen) + POS_W'(HDR_BYTES);

  assign goUnsplit = eopFire && lenOk && !isSplit;
  assign goFirst   = eopFire && lenOk && isSplit && !isSecond;
  assign goJoin    = eopFire && lenOk && matchHold;

  assign ctl.accept   = accept;
  assign ctl.commit   = goUnsplit || goFirst;
  assign ctl.wrBase   = wrBase;
  assign ctl.emitLen  = emitLenR;
  assign ctl.emitWord = wordCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_RECV;
      holdValid <= 1'b0;
      holdIdx   <= '0;
      holdLen   <= '0;
      emitLenR  <= '0;
      wordCnt   <= '0;
      lastWord  <= '0;
      emptyR    <= '0;
    end else begin
      if (eopFire) begin
        holdValid <= goFirst;
        if (goFirst) begin
          holdIdx <= idxF;
          holdLen <= newLen;
        end
      end
      unique case (state)
        ST_RECV: begin
          if (goUnsplit || goJoin) begin
            state    <= ST_EMIT;
            wordCnt  <= '0;
            emitLenR <= newLen;
            lastWord <= WORD_W'((totBytes - POS_W'(1)) >> 2);
            emptyR   <= 2'(3'd4 - {1'b0, totBytes[1:0]});
          end
        end
        ST_EMIT: begin
          if (wordCnt == lastWord) state <= ST_RECV;
          else wordCnt <= wordCnt + WORD_W'(1);
        end
        default: state <= ST_RECV;
      endcase
    end
  end

  assign outValid = (state == ST_EMIT);
  assign outSop   = outValid && (wordCnt == '0);
  assign outEop   = outValid && (wordCnt == lastWord);
  assign outEmpty = outEop ? emptyR : 2'd0;
  assign ivValid  = outSop;
endmodule

// File: rtl/frag_rejoin_strip.sv
module frag_rejoin_strip
  import rejoin_pkg::*;
#(
  parameter int DATA_BYTES = 2048
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [31:0]  inData,
  input  logic         inValid,
  input  logic         inSop,
  input  logic         inEop,
  input  logic [1:0]   inEmpty,
  output logic         inReady,
  output logic [31:0]  outData,
  output logic         outValid,
  output logic         outSop,
  output logic         outEop,
  output logic [1:0]   outEmpty,
  output logic [127:0] ivData,
  output logic         ivValid
);
  rejoinCtl_t       ctl;
  logic [31:0]      sigNow;
  logic [POS_W-1:0] rxBytes;

  rejoin_ctrl #(.DATA_BYTES(DATA_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inEop(inEop),
    .sigNow(sigNow), .rxBytes(rxBytes), .inReady(inReady), .ctl(ctl),
    .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outEmpty(outEmpty), .ivValid(ivValid)
  );

  rejoin_dpath #(.DATA_BYTES(DATA_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .inSop(inSop),
    .inEop(inEop), .inEmpty(inEmpty), .sigNow(sigNow), .rxBytes(rxBytes),
    .outData(outData), .ivData(ivData)
  );
endmodule

// File: rtl/rejoin_checker.sv
module rejoin_checker (
  input logic         clk,
  input logic         rstN,
  input logic         inReady,
  input logic         outValid,
  input logic         outSop,
  input logic         outEop,
  input logic [1:0]   outEmpty,
  input logic [127:0] ivData,
  input logic         ivValid
);
  a_r11_ready_low_while_out: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);
  a_r11_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outEop |=> outValid);
  a_r11_idle_after_eop: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outEop |=> !outValid);
  a_r3_start_with_sop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outSop);
  a_r3_single_sop: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outSop |=> !outSop);
  a_r3_empty_only_last: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outEop |-> outEmpty == 2'd0);
  a_r4_iv_on_sop: assert property (@(posedge clk) disable iff (!rstN)
    ivValid |-> outValid && outSop);
  a_r4_iv_stable: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outSop |-> $stable(ivData));
endmodule

bind frag_rejoin_strip rejoin_checker u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outSop(outSop), .outEop(outEop), .outEmpty(outEmpty),
  .ivData(ivData), .ivValid(ivValid)
);

// File: tb/tb_frag_rejoin_strip.sv
module tb_frag_rejoin_strip;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [31:0]  inData = '0;
  logic         inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [1:0]   inEmpty = '0;
  logic         inReady, outValid, outSop, outEop, ivValid;
  logic [31:0]  outData;
  logic [1:0]   outEmpty;
  logic [127:0] ivData;

  int nChecks = 0, nErr = 0;
  bit done = 0;

  logic [7:0] txBuf  [4096];
  logic [7:0] expBuf [4096];
  int txLen, expLen;
  logic [127:0] expIv;

  always #5 clk = ~clk;

  frag_rejoin_strip dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // protected frame: hdr(14) sig(4) iv(16) payload
  task automatic build(input int seed, input bit split, input bit second,
                       input int idx, input int sizeF, input int dLen);
    logic [31:0] sig;
    sig = {2'b00, 11'(idx), 11'(sizeF), 6'(seed), second, split};
    for (int j = 0; j < 14; j++) txBuf[j] = 8'(seed * 7 + j * 13 + 3);
    for (int j = 0; j < 4; j++) txBuf[14+j] = sig[31-8*j -: 8];
    for (int j = 0; j < 16; j++) txBuf[18+j] = 8'(seed * 3 + j * 29 + 1);
    for (int j = 0; j < dLen; j++) txBuf[34+j] = 8'(seed * 31 + j * 5 + 7);
    txLen = 34 + dLen;
  endtask

  task automatic expStart();
    for (int j = 0; j < 14; j++) expBuf[j] = txBuf[j];
    for (int j = 0; j < 16; j++) expIv[127-8*j -: 8] = txBuf[18+j];
    expLen = 14;
    for (int j = 34; j < txLen; j++) begin expBuf[expLen] = txBuf[j]; expLen++; end
  endtask

  task automatic expAppend();
    for (int j = 34; j < txLen; j++) begin expBuf[expLen] = txBuf[j]; expLen++; end
  endtask

  // ends at the negedge after the edge that accepts the last word
  task automatic sendTx();
    int words;
    words = (txLen + 3) / 4;
    for (int w = 0; w < words; w++) begin
      @(negedge clk);
      while (!inReady) @(negedge clk);
      inValid = 1'b1;
      inSop   = (w == 0);
      inEop   = (w == words - 1);
      inEmpty = (w == words - 1) ? 2'(4 * words - txLen) : 2'd0;
      for (int i = 0; i < 4; i++)
        inData[31-8*i -: 8] = (4*w+i < txLen) ? txBuf[4*w+i] : 8'h00;
    end
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
  endtask

  task automatic checkOut(input string req);
    int words, badFrame, badReady, badBytes, firstA, firstE;
    bit ivOk;
    words = (expLen + 3) / 4;
    badFrame = 0; badReady = 0; badBytes = 0; firstA = 0; firstE = 0; ivOk = 0;
    for (int w = 0; w < words; w++) begin
      if (!outValid || inReady) badReady++;
      if (outSop != (w == 0) || outEop != (w == words - 1)) badFrame++;
      if (w == words - 1 && outEmpty != 2'(4 * words - expLen)) badFrame++;
      if (w != words - 1 && outEmpty != 2'd0) badFrame++;
      if (w == 0) ivOk = ivValid && (ivData == expIv);
      else if (ivValid) ivOk = 0;
      for (int i = 0; i < 4; i++)
        if (4*w+i < expLen && outData[31-8*i -: 8] != expBuf[4*w+i]) begin
          if (badBytes == 0) begin
            firstA = outData[31-8*i -: 8]; firstE = expBuf[4*w+i];
          end
          badBytes++;
        end
      @(negedge clk);
    end
    if (outValid) badReady++;
    chk(badBytes == 0, req, "payload byte", firstA, firstE);
    chk(badFrame == 0, "R3", "framing errors", badFrame, 0);
    chk(ivOk, "R4", "iv on sop", ivOk, 1);
    chk(badReady == 0, "R11", "timing errors", badReady, 0);
  endtask

  task automatic checkNone(input string req);
    int seen = 0;
    for (int c = 0; c < 6; c++) begin
      if (outValid) seen++;
      @(negedge clk);
    end
    chk(seen == 0, req, "unexpected output words", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!outValid && !ivValid, "R1", "outValid|ivValid", outValid | ivValid, 0);
    chk(inReady, "R1", "inReady", inReady, 1);

    // R2: unsplit frames, every payload length 0..40
    for (int len = 0; len <= 40; len++) begin
      build(len + 1, 0, 0, len, len, len);
      expStart(); sendTx(); checkOut("R2");
    end

    // R5/R6: all fragment length pairs 0..7, second header differs
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        build(100 + a, 1, 0, a * 8 + b, a, a);
        expStart(); sendTx(); checkNone("R5");
        build(200 + b, 1, 1, a * 8 + b, b, b);
        expAppend(); sendTx(); checkOut("R6");
      end

    // R6: large pair
    build(7, 1, 0, 1000, 1468, 1468); expStart(); sendTx(); checkNone("R5");
    build(8, 1, 1, 1000, 500, 500);   expAppend(); sendTx(); checkOut("R6");

    // R7: mismatched index drops held, correct index then orphaned
    build(9, 1, 0, 5, 10, 10);  sendTx(); checkNone("R5");
    build(10, 1, 1, 6, 10, 10); sendTx(); checkNone("R7");
    build(11, 1, 1, 5, 10, 10); sendTx(); checkNone("R7");
    // R7: orphan second with nothing held
    build(12, 1, 1, 0, 3, 3);   sendTx(); checkNone("R7");
    build(13, 0, 0, 0, 9, 9);   expStart(); sendTx(); checkOut("R2");

    // R8: intervening unsplit frame releases held part
    build(14, 1, 0, 9, 12, 12); sendTx(); checkNone("R5");
    build(15, 0, 0, 0, 5, 5);   expStart(); sendTx(); checkOut("R8");
    build(16, 1, 1, 9, 12, 12); sendTx(); checkNone("R8");

    // R9: size field mismatch, short frame, bad second drops both
    build(17, 0, 0, 0, 10, 11); sendTx(); checkNone("R9");
    build(18, 0, 0, 0, 0, 0);   txLen = 30; sendTx(); checkNone("R9");
    build(19, 1, 0, 3, 8, 8);   sendTx(); checkNone("R5");
    build(20, 1, 1, 3, 5, 6);   sendTx(); checkNone("R9");
    build(21, 1, 1, 3, 6, 6);   sendTx(); checkNone("R9");

    // R10: capacity exceeded, then exactly at capacity
    build(22, 1, 0, 4, 1468, 1468); sendTx(); checkNone("R5");
    build(23, 1, 1, 4, 600, 600);   sendTx(); checkNone("R10");
    build(24, 1, 0, 2, 1024, 1024); expStart(); sendTx(); checkNone("R5");
    build(25, 1, 1, 2, 1024, 1024); expAppend(); sendTx(); checkOut("R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule